// File: doc/BRIEF.md
# Single-Wire Half-Duplex UART Transceiver

This block sends and receives asynchronous serial bytes over one shared, open-drain data wire. A byte written on the parallel port is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit. The block sends the frame by pulling the wire low for each 0 bit and letting the external pull-up supply each 1 bit. When no frame is being sent, the driver is always released. A baud tick arriving at the oversampling rate times every bit. Transmission never waits for the wire to be quiet. Resolving collisions between talkers is left to whatever arbitrates the bus outside the block.

In half-duplex mode the receiver samples the same wire that the transmitter drives. As a result, every byte the block sends is also reported on its receive output, and the separate receive pin is ignored. With half-duplex mode off, the receiver listens to the receive pin instead. A single holding register lets software queue one byte while a frame is in flight. Selecting half-duplex together with any other special line mode is flagged as an invalid configuration, and writes are refused while that configuration holds.

Top module: `sw_uart_hd`

## Requirements
- R1: After reset, line_drive_low, tx_busy, rx_valid, rx_ferr and cfg_err are 0, and wr_ready is 1 while the configuration is valid.
- R2: A frame on the wire is one start bit at level 0, then wr_data bit 0 through bit 7, then one stop bit at level 1. Each bit lasts OVS baud ticks. line_drive_low=1 means the wire is pulled to 0.
- R3: line_drive_low is 0 whenever tx_busy is 0, including idle time and reception of frames from other talkers.
- R4: A write is taken only when wr_valid, wr_ready and tx_en are all 1. With tx_en at 0 a write has no effect: no frame starts and wr_ready stays 1.
- R5: A frame starts regardless of the wire level. tx_busy and line_drive_low are both 1 two clock edges after the write is taken, and tx_busy stays 1 until the end of the stop bit.
- R6: One further write is accepted while a frame is being sent. wr_ready is then 0 until that byte moves into the shifter, and writes made while wr_ready is 0 are dropped. The held byte is sent right after the current frame.
- R7: With hd_sel=1 the receiver samples the wire, so each sent byte is also reported on rx_data with rx_valid. Activity on rx_pin produces no rx_valid.
- R8: With hd_sel=0 the receiver samples rx_pin, and frames sent on the wire are not reported.
- R9: A start bit is accepted only if the input is still 0 half a bit after the falling edge. A low pulse of 2 baud ticks with OVS=8 produces no rx_valid.
- R10: The stop bit is sampled at mid-bit. If it is 0, rx_ferr is 1 in the same cycle as rx_valid; otherwise rx_ferr is 0.
- R11: cfg_err is 1 one clock after hd_sel=1 is seen together with any nonzero bit of alt_mode. While cfg_err is 1, wr_ready is 0 and writes start no frame. hd_sel=0 with alt_mode nonzero is not an error.
- R12: rx_valid is a one-clock pulse per received frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at OVS times the bit rate |
| hd_sel | input | 1 | 1 selects the shared-wire receive path |
| alt_mode | input | MODE_W | Requests for other special line modes |
| tx_en | input | 1 | Transmit enable; gates write acceptance |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | DATA_W | Byte to send |
| wr_ready | output | 1 | Holding register free and configuration valid |
| tx_busy | output | 1 | Frame in progress, start through stop bit |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| line_in | input | 1 | Sampled level of the shared wire |
| rx_pin | input | 1 | Separate receive input, used only when hd_sel=0 |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_ferr | output | 1 | Stop bit sampled low, valid with rx_valid |
| cfg_err | output | 1 | Half-duplex selected together with another special mode |

## Verification
The bench builds the block with OVS=8, DATA_W=8, SYNC_STAGES=2 and MODE_W=4. A frame of 80 baud ticks at one tick every two clocks is short enough to loop all 256 byte values through the shared wire. For each byte the bench checks every bit's level at mid-bit and the echoed byte. The half-bit window of 4 ticks makes a 2-tick glitch a clear rejection case. The small frame also leaves room for the framing-error, full-duplex, holding-register and invalid-configuration scenarios.

// File: rtl/sw_uart_pkg.sv
package sw_uart_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/sw_uart_sync.sv
module sw_uart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= '1;
    else     ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/sw_uart_txer.sv
module sw_uart_txer #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  output logic              busy,
  output logic              drive_low
);
  localparam int FW  = DATA_W + 2;
  localparam int CW  = $clog2(OVS);
  localparam int BIW = $clog2(FW);
  localparam logic [CW-1:0]  CNT_LAST = CW'(OVS - 1);
  localparam logic [BIW-1:0] BIT_LAST = BIW'(FW - 1);

  logic [FW-1:0]  frame_q;
  logic [BIW-1:0] bit_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q;
  logic           drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '1;
      bit_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      drv_q   <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        frame_q <= {1'b1, start_data, 1'b0};
        bit_q   <= '0;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
        drv_q   <= 1'b1;
      end
    end else if (tick) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (bit_q == BIT_LAST) begin
          busy_q <= 1'b0;
          drv_q  <= 1'b0;
        end else begin
          bit_q   <= bit_q + 1'b1;
          frame_q <= {1'b1, frame_q[FW-1:1]};
          drv_q   <= ~frame_q[1];
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign drive_low = drv_q;
endmodule

// File: rtl/sw_uart_rxer.sv
module sw_uart_rxer
  import sw_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              ferr
);
  localparam int CW  = $clog2(OVS);
  localparam int BIW = $clog2(DATA_W);
  localparam logic [CW-1:0]  CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0]  CNT_HALF = CW'(OVS / 2 - 1);
  localparam logic [BIW-1:0] BIT_LAST = BIW'(DATA_W - 1);

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [BIW-1:0]    bit_q;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              ferr_q;

  always_ff @(posedge clk) begin
    valid_q <= 1'b0;
    ferr_q  <= 1'b0;
    if (rst) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            shift_q <= {line, shift_q[DATA_W-1:1]};
            if (bit_q == BIT_LAST) st_q <= RX_STOP;
            else                   bit_q <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            data_q  <= shift_q;
            valid_q <= 1'b1;
            ferr_q  <= ~line;
            st_q    <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign ferr  = ferr_q;
endmodule

// File: rtl/sw_uart_hd.sv
module sw_uart_hd #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              hd_sel,
  input  logic [MODE_W-1:0] alt_mode,
  input  logic              tx_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              tx_busy,
  output logic              line_drive_low,
  input  logic              line_in,
  input  logic              rx_pin,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ferr,
  output logic              cfg_err
);
  logic              cfg_err_q;
  logic              hold_full_q;
  logic [DATA_W-1:0] hold_q;
  logic              wr_fire;
  logic              tx_start;
  logic              busy_w;
  logic              rx_src;
  logic              rx_line;

  always_ff @(posedge clk) begin
    if (rst) cfg_err_q <= 1'b0;
    else     cfg_err_q <= hd_sel & (|alt_mode);
  end

  assign wr_ready = ~hold_full_q & ~cfg_err_q;
  assign wr_fire  = wr_valid & wr_ready & tx_en;
  assign tx_start = hold_full_q & ~busy_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else if (wr_fire) begin
      hold_full_q <= 1'b1;
      hold_q      <= wr_data;
    end else if (tx_start) begin
      hold_full_q <= 1'b0;
    end
  end

  sw_uart_txer #(
    .DATA_W (DATA_W),
    .OVS    (OVS)
  ) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tick       (baud_tick),
    .start      (tx_start),
    .start_data (hold_q),
    .busy       (busy_w),
    .drive_low  (line_drive_low)
  );

  assign tx_busy = busy_w;
  assign rx_src  = hd_sel ? line_in : rx_pin;

  sw_uart_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_src),
    .q   (rx_line)
  );

  sw_uart_rxer #(
    .DATA_W (DATA_W),
    .OVS    (OVS)
  ) u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .line  (rx_line),
    .data  (rx_data),
    .valid (rx_valid),
    .ferr  (rx_ferr)
  );

  assign cfg_err = cfg_err_q;
endmodule

// File: rtl/sw_uart_hd_chk.sv
module sw_uart_hd_chk (
  input logic clk,
  input logic rst,
  input logic tx_busy,
  input logic line_drive_low,
  input logic wr_ready,
  input logic cfg_err,
  input logic rx_valid,
  input logic rx_ferr
);
  // R3: driver released outside a frame
  a_r3_release_idle: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> !line_drive_low);

  // R5: frame begins with the wire pulled low
  a_r5_start_drives_low: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> line_drive_low);

  // R2: stop bit is a released wire
  a_r2_stop_released: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> !$past(line_drive_low));

  // R11: invalid configuration refuses writes
  a_r11_cfg_blocks_write: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !wr_ready);

  // R10: framing error only with a received frame
  a_r10_ferr_with_valid: assert property (@(posedge clk) disable iff (rst)
    rx_ferr |-> rx_valid);

  // R12: receive strobe lasts one clock
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind sw_uart_hd sw_uart_hd_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .tx_busy        (tx_busy),
  .line_drive_low (line_drive_low),
  .wr_ready       (wr_ready),
  .cfg_err        (cfg_err),
  .rx_valid       (rx_valid),
  .rx_ferr        (rx_ferr)
);

// File: tb/tb_sw_uart_hd.sv
module tb_sw_uart_hd;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 8;
  localparam int DATA_W     = 8;
  localparam int MODE_W     = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              baud_tick;
  logic              hd_sel = 1'b1;
  logic [MODE_W-1:0] alt_mode = '0;
  logic              tx_en = 1'b1;
  logic              wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_ready;
  logic              tx_busy;
  logic              line_drive_low;
  logic              line_in;
  logic              rx_pin = 1'b1;
  logic [DATA_W-1:0] rx_data;
  logic              rx_valid;
  logic              rx_ferr;
  logic              cfg_err;
  logic              ext_low = 1'b0;

  int nchk = 0;
  int nfail = 0;
  int rx_cnt = 0;
  int rel_viol = 0;
  int pulse_viol = 0;
  logic [DATA_W-1:0] log_data [8];
  logic              log_ferr [8];
  logic              prev_valid = 1'b0;

  assign line_in = ~(line_drive_low | ext_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) baud_tick <= 1'b0;
    else     baud_tick <= ~baud_tick;
  end

  sw_uart_hd #(
    .DATA_W      (DATA_W),
    .OVS         (OVS),
    .SYNC_STAGES (2),
    .MODE_W      (MODE_W)
  ) dut (
    .clk            (clk),
    .rst            (rst),
    .baud_tick      (baud_tick),
    .hd_sel         (hd_sel),
    .alt_mode       (alt_mode),
    .tx_en          (tx_en),
    .wr_valid       (wr_valid),
    .wr_data        (wr_data),
    .wr_ready       (wr_ready),
    .tx_busy        (tx_busy),
    .line_drive_low (line_drive_low),
    .line_in        (line_in),
    .rx_pin         (rx_pin),
    .rx_data        (rx_data),
    .rx_valid       (rx_valid),
    .rx_ferr        (rx_ferr),
    .cfg_err        (cfg_err)
  );

  // output monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (rx_cnt < 8) begin
          log_data[rx_cnt] = rx_data;
          log_ferr[rx_cnt] = rx_ferr;
        end
        rx_cnt = rx_cnt + 1;
      end
      if (line_drive_low && !tx_busy) rel_viol = rel_viol + 1;
      if (rx_valid && prev_valid) pulse_viol = pulse_viol + 1;
      prev_valid = rx_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; ) begin
      @(posedge clk);
      if (baud_tick) i = i + 1;
    end
  endtask

  task automatic write_byte(input logic [DATA_W-1:0] b);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_busy(input logic lvl);
    for (int i = 0; i < 4000 && tx_busy !== lvl; i++) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 4000 && rx_cnt < n; i++) @(negedge clk);
  endtask

  // drive a frame from outside: on the wire (on_pin=0) or on rx_pin
  task automatic ext_frame(input logic [DATA_W-1:0] b, input logic stop_lvl,
                           input bit on_pin);
    logic [DATA_W+1:0] f;
    f = {stop_lvl, b, 1'b0};
    for (int k = 0; k < DATA_W + 2; k++) begin
      @(negedge clk);
      if (on_pin) rx_pin = f[k];
      else        ext_low = ~f[k];
      wait_ticks(OVS);
    end
    @(negedge clk);
    rx_pin  = 1'b1;
    ext_low = 1'b0;
    wait_ticks(2 * OVS);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nfail = nfail + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(line_drive_low == 1'b0, "R1", "line_drive_low", line_drive_low, 0);
    chk(tx_busy == 1'b0, "R1", "tx_busy", tx_busy, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(wr_ready == 1'b1, "R1", "wr_ready", wr_ready, 1);
    chk(cfg_err == 1'b0, "R1", "cfg_err", cfg_err, 0);

    // R2 R7 R10: loop every byte value through the shared wire
    for (int b = 0; b < 256; b++) begin
      logic [DATA_W+1:0] f;
      f = {1'b1, 8'(b), 1'b0};
      rx_cnt = 0;
      write_byte(8'(b));
      wait_busy(1'b1);
      for (int k = 0; k < DATA_W + 2; k++) begin
        wait_ticks(k == 0 ? OVS / 2 : OVS);
        @(negedge clk);
        chk(line_drive_low == ~f[k], "R2", $sformatf("bit %0d of byte %0d", k, b),
            line_drive_low, ~f[k]);
      end
      wait_busy(1'b0);
      wait_rx(1);
      chk(rx_cnt == 1, "R7", "echo count", rx_cnt, 1);
      chk(log_data[0] == 8'(b), "R7", "echo data", log_data[0], b);
      chk(log_ferr[0] == 1'b0, "R10", "echo ferr", log_ferr[0], 0);
    end

    // R4 write with tx_en low is ignored
    tx_en = 1'b0;
    rx_cnt = 0;
    write_byte(8'h5A);
    begin
      int seen = 0;
      for (int i = 0; i < 60 * OVS; i++) begin
        @(negedge clk);
        if (tx_busy || line_drive_low) seen = seen + 1;
      end
      chk(seen == 0, "R4", "activity with tx_en low", seen, 0);
    end
    chk(wr_ready == 1'b1, "R4", "wr_ready after ignored write", wr_ready, 1);
    chk(rx_cnt == 0, "R4", "rx after ignored write", rx_cnt, 0);
    tx_en = 1'b1;

    // R5 transmission starts while the wire is held low
    @(negedge clk);
    ext_low = 1'b1;
    write_byte(8'hA5);
    @(negedge clk);
    chk(tx_busy == 1'b1, "R5", "tx_busy two edges after write", tx_busy, 1);
    chk(line_drive_low == 1'b1, "R5", "start bit drive", line_drive_low, 1);
    wait_ticks(OVS / 2);
    @(negedge clk);
    ext_low = 1'b0;
    begin
      int gone = 0;
      for (int i = 0; i < 10 * OVS * 2 && tx_busy; i++) begin
        @(negedge clk);
        if (!tx_busy) gone = i;
      end
      chk(gone > 8 * OVS * 2, "R5", "busy held through frame", gone, 9 * OVS * 2);
    end
    wait_ticks(30 * OVS);

    // R6 holding register: one queued byte, third write dropped
    rx_cnt = 0;
    write_byte(8'h3C);
    wait_busy(1'b1);
    @(negedge clk);
    chk(wr_ready == 1'b1, "R6", "ready during first frame", wr_ready, 1);
    write_byte(8'hC3);
    chk(wr_ready == 1'b0, "R6", "ready with hold full", wr_ready, 0);
    write_byte(8'h77);
    wait_rx(2);
    wait_ticks(30 * OVS);
    chk(rx_cnt == 2, "R6", "frames sent", rx_cnt, 2);
    chk(log_data[0] == 8'h3C, "R6", "first byte", log_data[0], 8'h3C);
    chk(log_data[1] == 8'hC3, "R6", "held byte", log_data[1], 8'hC3);

    // R3 R7 frame from another talker on the wire
    rx_cnt = 0;
    ext_frame(8'h96, 1'b1, 1'b0);
    chk(rx_cnt == 1, "R7", "external frame count", rx_cnt, 1);
    chk(log_data[0] == 8'h96, "R7", "external frame data", log_data[0], 8'h96);
    chk(log_ferr[0] == 1'b0, "R10", "external frame ferr", log_ferr[0], 0);

    // R10 stop bit held low
    rx_cnt = 0;
    ext_frame(8'h81, 1'b0, 1'b0);
    chk(rx_cnt == 1, "R10", "framing error frame count", rx_cnt, 1);
    chk(log_ferr[0] == 1'b1, "R10", "ferr flag", log_ferr[0], 1);
    chk(log_data[0] == 8'h81, "R10", "ferr data", log_data[0], 8'h81);
    wait_ticks(30 * OVS);

    // R9 short low pulse rejected
    rx_cnt = 0;
    @(negedge clk);
    ext_low = 1'b1;
    wait_ticks(2);
    @(negedge clk);
    ext_low = 1'b0;
    wait_ticks(20 * OVS);
    chk(rx_cnt == 0, "R9", "glitch frames", rx_cnt, 0);

    // R7 rx_pin ignored in half-duplex
    rx_cnt = 0;
    ext_frame(8'h99, 1'b1, 1'b1);
    wait_ticks(4 * OVS);
    chk(rx_cnt == 0, "R7", "rx_pin frames in half-duplex", rx_cnt, 0);

    // R8 full duplex: rx_pin heard, own frames not
    hd_sel = 1'b0;
    wait_ticks(4 * OVS);
    rx_cnt = 0;
    ext_frame(8'h66, 1'b1, 1'b1);
    chk(rx_cnt == 1, "R8", "rx_pin frame count", rx_cnt, 1);
    chk(log_data[0] == 8'h66, "R8", "rx_pin frame data", log_data[0], 8'h66);
    rx_cnt = 0;
    write_byte(8'h11);
    wait_busy(1'b1);
    wait_busy(1'b0);
    wait_ticks(4 * OVS);
    chk(rx_cnt == 0, "R8", "own frame not heard", rx_cnt, 0);

    // R11 configuration conflicts
    alt_mode = 4'b0100;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R11", "no error without half-duplex", cfg_err, 0);
    hd_sel = 1'b1;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R11", "cfg_err", cfg_err, 1);
    chk(wr_ready == 1'b0, "R11", "wr_ready in conflict", wr_ready, 0);
    write_byte(8'hF0);
    repeat (8) @(negedge clk);
    chk(tx_busy == 1'b0, "R11", "no frame in conflict", tx_busy, 0);
    alt_mode = '0;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R11", "cfg_err cleared", cfg_err, 0);
    chk(wr_ready == 1'b1, "R11", "wr_ready restored", wr_ready, 1);

    // R3 R12 accumulated monitors
    chk(rel_viol == 0, "R3", "drive outside frame", rel_viol, 0);
    chk(pulse_viol == 0, "R12", "rx_valid longer than one clock", pulse_viol, 0);

    finish_run();
  end
endmodule